// File: doc/BRIEF.md
# Privileged Key Slot Store

This block holds secret keys in a small array of numbered slots and hands them to a crypto engine on request. Software never gets key bits back. It can load a slot, invalidate it, set the store's current privilege, or ask for a slot's key to be applied by the engine. Each slot carries three attributes next to its key: a privilege level, a lock flag and a secure-mode flag. These attributes decide whether a key may be used, whether it may be replaced, and where a derived result may go. A separate result-sink port lets the engine write derived keys straight back into a slot, so that protected results stay inside the store.

Every command is decided and answered in one cycle. An accepted command gives a one-cycle `done` pulse. A rejected one gives a one-cycle `err` pulse and leaves every slot unchanged. It also sets a sticky error flag, and an error code records which rule failed. The key bus to the engine carries a key only in the cycle a use request is granted. In all other cycles it is zero.

Top module: `slot_keystore`

## Requirements
- R1: After reset every slot is invalid and unlocked, the current privilege is 0, and all outputs are 0: `done`, `err`, `err_code`, `err_sticky`, `res_err`, `use_valid` and `use_key`.
- R2: A load (`cmd_op`=0) to an unlocked slot stores `cmd_key` together with `cmd_priv`, `cmd_secure` and `cmd_lock`, marks the slot valid, and pulses `done`.
- R3: A use request (`cmd_op`=3) on a valid slot whose privilege is greater than or equal to the current privilege is granted. In the next cycle `use_valid`, `done` and the slot's key on `use_key` appear for one cycle, with `cmd_dest_slot` and `cmd_to_sw` copied to `use_dest_slot` and `use_to_sw`.
- R4: A use request on a valid slot whose privilege is below the current privilege is rejected with `err_code`=1.
- R5: A use request on an invalid slot is rejected with `err_code`=3, and `use_key` stays 0.
- R6: A use request on a secure-mode slot with `cmd_sensitive`=1 (CBC decrypt or HMAC) and `cmd_to_sw`=1 is rejected with `err_code`=4. The same request aimed at a slot (`cmd_to_sw`=0), or with `cmd_sensitive`=0, is granted.
- R7: A load or an invalidate (`cmd_op`=1) on a locked slot is rejected with `err_code`=2, and the stored key remains usable unchanged. A lock flag clears only at reset.
- R8: An invalidate of an unlocked slot pulses `done` and makes the slot invalid.
- R9: A set-privilege command (`cmd_op`=2) always pulses `done` and makes `cmd_priv` (0 to 3) the current privilege.
- R10: `use_key` is zero in every cycle in which `use_valid` is low.
- R11: Any rejection sets `err_sticky`, which then stays high until reset. `err_code` holds the code of the latest rejection, and a command error takes precedence over a sink error raised in the same cycle.
- R12: A result-sink write (`res_valid`) stores `res_key` into `res_slot` as a valid, unlocked slot with `res_priv` and `res_secure`. It is rejected with a `res_err` pulse and `err_code`=5 if a load or invalidate targets the same slot in the same cycle. Otherwise it is rejected with `err_code`=2 if the target slot is locked.
- R13: Each command yields exactly one of `done` or `err` in the cycle after it is presented. Neither pulses without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 load, 1 invalidate, 2 set privilege, 3 use |
| cmd_slot | input | 3 | Target slot of the command |
| cmd_key | input | 256 | Key for a load |
| cmd_priv | input | 2 | Slot privilege for a load, new current privilege for set privilege |
| cmd_secure | input | 1 | Secure-mode attribute for a load |
| cmd_lock | input | 1 | Lock attribute for a load |
| cmd_sensitive | input | 1 | Use request is a CBC decrypt or HMAC |
| cmd_to_sw | input | 1 | Use result goes to software (1) or to a slot (0) |
| cmd_dest_slot | input | 3 | Destination slot for the use result |
| res_valid | input | 1 | Derived key from the engine present |
| res_slot | input | 3 | Slot to receive the derived key |
| res_key | input | 256 | Derived key |
| res_secure | input | 1 | Secure-mode attribute of the derived key |
| res_priv | input | 2 | Privilege of the derived key |
| done | output | 1 | Command accepted (one-cycle pulse) |
| err | output | 1 | Command rejected (one-cycle pulse) |
| err_code | output | 3 | Code of the latest rejection |
| err_sticky | output | 1 | Set by any rejection, cleared by reset |
| res_err | output | 1 | Result-sink write rejected (one-cycle pulse) |
| use_valid | output | 1 | Key granted to the engine this cycle |
| use_key | output | 256 | Granted key, zero otherwise |
| use_dest_slot | output | 3 | Destination slot of the granted operation |
| use_to_sw | output | 1 | Granted operation's result goes to software |

## Verification
Every output is registered once. The command or sink write presented before a rising edge shows its `done`, `err`, `res_err`, `err_code`, `err_sticky` and `use_*` results right after that edge. Slot and privilege state changes become visible to a command presented one cycle later. The bench drives each stimulus on a falling edge, compares all outputs on the following falling edge against its own slot model, and only then drives the next stimulus. Back-to-back commands therefore also test that state written by one command is seen by the next. Reset release goes through a two-stage synchronizer, so the bench waits three falling edges after releasing reset before the first command.

// File: rtl/keystore_pkg.sv
package keystore_pkg;

  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_INVAL   = 2'd1,
    OP_SETPRIV = 2'd2,
    OP_USE     = 2'd3
  } ks_op_e;

  typedef enum logic [2:0] {
    EC_NONE  = 3'd0,
    EC_PRIV  = 3'd1,
    EC_LOCK  = 3'd2,
    EC_EMPTY = 3'd3,
    EC_ROUTE = 3'd4,
    EC_CLASH = 3'd5
  } ks_err_e;

endpackage

// File: rtl/ks_slot.sv
module ks_slot #(
  parameter int KEYW  = 256,
  parameter int PRIVW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEYW-1:0]  wr_key,
  input  logic [PRIVW-1:0] wr_priv,
  input  logic             wr_secure,
  input  logic             wr_lock,
  input  logic             clr_en,
  output logic [KEYW-1:0]  key,
  output logic [PRIVW-1:0] priv,
  output logic             valid,
  output logic             secure,
  output logic             lock
);

  logic [KEYW-1:0]  key_d;
  logic [PRIVW-1:0] priv_d;
  logic             valid_d, secure_d, lock_d;
  logic             upd_en;

  assign upd_en = wr_en | clr_en;

  always_comb begin
    key_d    = '0;
    priv_d   = '0;
    valid_d  = 1'b0;
    secure_d = 1'b0;
    lock_d   = lock;
    if (wr_en) begin
      key_d    = wr_key;
      priv_d   = wr_priv;
      valid_d  = 1'b1;
      secure_d = wr_secure;
      lock_d   = wr_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key    <= '0;
      priv   <= '0;
      valid  <= 1'b0;
      secure <= 1'b0;
      lock   <= 1'b0;
    end else if (upd_en) begin
      key    <= key_d;
      priv   <= priv_d;
      valid  <= valid_d;
      secure <= secure_d;
      lock   <= lock_d;
    end
  end

endmodule

// File: rtl/ks_policy.sv
module ks_policy
  import keystore_pkg::*;
#(
  parameter int PRIVW = 2
) (
  input  logic [1:0]       op,
  input  logic             slot_valid,
  input  logic             slot_secure,
  input  logic             slot_lock,
  input  logic [PRIVW-1:0] slot_priv,
  input  logic [PRIVW-1:0] cur_priv,
  input  logic             sensitive,
  input  logic             to_sw,
  output logic             accept,
  output ks_err_e          code
);

  always_comb begin
    code = EC_NONE;
    unique case (op)
      OP_LOAD, OP_INVAL: begin
        if (slot_lock) code = EC_LOCK;
      end
      OP_SETPRIV: code = EC_NONE;
      default: begin
        if (!slot_valid)                           code = EC_EMPTY;
        else if (slot_priv < cur_priv)             code = EC_PRIV;
        else if (slot_secure && sensitive && to_sw) code = EC_ROUTE;
      end
    endcase
    accept = (code == EC_NONE);
  end

endmodule

// File: rtl/slot_keystore.sv
module slot_keystore
  import keystore_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int KEYW  = 256,
  parameter int PRIVW = 2,
  localparam int SLOTW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [SLOTW-1:0] cmd_slot,
  input  logic [KEYW-1:0]  cmd_key,
  input  logic [PRIVW-1:0] cmd_priv,
  input  logic             cmd_secure,
  input  logic             cmd_lock,
  input  logic             cmd_sensitive,
  input  logic             cmd_to_sw,
  input  logic [SLOTW-1:0] cmd_dest_slot,
  input  logic             res_valid,
  input  logic [SLOTW-1:0] res_slot,
  input  logic [KEYW-1:0]  res_key,
  input  logic             res_secure,
  input  logic [PRIVW-1:0] res_priv,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code,
  output logic             err_sticky,
  output logic             res_err,
  output logic             use_valid,
  output logic [KEYW-1:0]  use_key,
  output logic [SLOTW-1:0] use_dest_slot,
  output logic             use_to_sw
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // slot array
  logic [KEYW-1:0]  slot_key    [NSLOT];
  logic [PRIVW-1:0] slot_priv   [NSLOT];
  logic             slot_valid  [NSLOT];
  logic             slot_secure [NSLOT];
  logic [NSLOT-1:0] lock_vec;
  logic [NSLOT-1:0] cmd_wr, res_wr, clr_vec;

  logic    cmd_ok, cmd_bad, pol_accept, res_ok, res_bad, res_clash, res_locked;
  logic    is_load, is_inval, writes_slot;
  ks_err_e pol_code;

  assign is_load     = (cmd_op == OP_LOAD);
  assign is_inval    = (cmd_op == OP_INVAL);
  assign writes_slot = cmd_valid && (is_load || is_inval);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic hit_cmd, hit_res;
    assign hit_cmd    = (cmd_slot == SLOTW'(i));
    assign hit_res    = (res_slot == SLOTW'(i));
    assign cmd_wr[i]  = cmd_ok && is_load  && hit_cmd;
    assign clr_vec[i] = cmd_ok && is_inval && hit_cmd;
    assign res_wr[i]  = res_ok && hit_res;

    ks_slot #(.KEYW(KEYW), .PRIVW(PRIVW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_en     (cmd_wr[i] | res_wr[i]),
      .wr_key    (res_wr[i] ? res_key    : cmd_key),
      .wr_priv   (res_wr[i] ? res_priv   : cmd_priv),
      .wr_secure (res_wr[i] ? res_secure : cmd_secure),
      .wr_lock   (res_wr[i] ? 1'b0       : cmd_lock),
      .clr_en    (clr_vec[i]),
      .key       (slot_key[i]),
      .priv      (slot_priv[i]),
      .valid     (slot_valid[i]),
      .secure    (slot_secure[i]),
      .lock      (lock_vec[i])
    );
  end

  logic [PRIVW-1:0] cur_priv_q, cur_priv_d;
  logic             priv_en;

  ks_policy #(.PRIVW(PRIVW)) u_policy (
    .op          (cmd_op),
    .slot_valid  (slot_valid[cmd_slot]),
    .slot_secure (slot_secure[cmd_slot]),
    .slot_lock   (lock_vec[cmd_slot]),
    .slot_priv   (slot_priv[cmd_slot]),
    .cur_priv    (cur_priv_q),
    .sensitive   (cmd_sensitive),
    .to_sw       (cmd_to_sw),
    .accept      (pol_accept),
    .code        (pol_code)
  );

  assign cmd_ok     = cmd_valid && pol_accept;
  assign cmd_bad    = cmd_valid && !pol_accept;
  assign res_clash  = res_valid && writes_slot && (cmd_slot == res_slot);
  assign res_locked = res_valid && lock_vec[res_slot];
  assign res_ok     = res_valid && !res_clash && !res_locked;
  assign res_bad    = res_valid && !res_ok;

  // next state
  logic             done_d, err_d, res_err_d, sticky_d, grant;
  logic [2:0]       code_d;
  logic [KEYW-1:0]  ukey_d;
  logic [SLOTW-1:0] udest_d;
  logic             usw_d;

  always_comb begin
    grant      = cmd_ok && (cmd_op == OP_USE);
    done_d     = cmd_ok;
    err_d      = cmd_bad;
    res_err_d  = res_bad;
    sticky_d   = err_sticky | cmd_bad | res_bad;
    priv_en    = cmd_ok && (cmd_op == OP_SETPRIV);
    cur_priv_d = cmd_priv;
    if (cmd_bad)      code_d = pol_code;
    else if (res_bad) code_d = res_clash ? EC_CLASH : EC_LOCK;
    else              code_d = err_code;
    ukey_d  = grant ? slot_key[cmd_slot] : '0;
    udest_d = grant ? cmd_dest_slot : '0;
    usw_d   = grant && cmd_to_sw;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done          <= 1'b0;
      err           <= 1'b0;
      res_err       <= 1'b0;
      err_code      <= '0;
      err_sticky    <= 1'b0;
      use_valid     <= 1'b0;
      use_key       <= '0;
      use_dest_slot <= '0;
      use_to_sw     <= 1'b0;
    end else begin
      done          <= done_d;
      err           <= err_d;
      res_err       <= res_err_d;
      err_code      <= code_d;
      err_sticky    <= sticky_d;
      use_valid     <= grant;
      use_key       <= ukey_d;
      use_dest_slot <= udest_d;
      use_to_sw     <= usw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cur_priv_q <= '0;
    else if (priv_en) cur_priv_q <= cur_priv_d;
  end

endmodule

// File: rtl/ks_chk.sv
module ks_chk #(
  parameter int NSLOT = 8,
  parameter int KEYW  = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             done,
  input logic             err,
  input logic             res_err,
  input logic             err_sticky,
  input logic             use_valid,
  input logic [KEYW-1:0]  use_key,
  input logic [NSLOT-1:0] lock_vec
);

  // R10
  key_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !use_valid |-> (use_key == '0));

  // R13
  cmd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (done ^ err));

  // R13
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!done && !err));

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R11
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err || res_err) |-> err_sticky);

  // R7
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lock_vec) & ~lock_vec) == '0));

  // R3
  grant_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_valid |-> (done && !err));

endmodule

bind slot_keystore ks_chk #(.NSLOT(NSLOT), .KEYW(KEYW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cmd_valid  (cmd_valid),
  .done       (done),
  .err        (err),
  .res_err    (res_err),
  .err_sticky (err_sticky),
  .use_valid  (use_valid),
  .use_key    (use_key),
  .lock_vec   (lock_vec)
);

// File: tb/sim_slot_keystore.sv
`timescale 1ns/1ps
module sim_slot_keystore;

  localparam int NS = 8;
  localparam int KW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 0;
  logic [1:0]    cmd_op = 0;
  logic [2:0]    cmd_slot = 0;
  logic [KW-1:0] cmd_key = '0;
  logic [1:0]    cmd_priv = 0;
  logic          cmd_secure = 0, cmd_lock = 0, cmd_sensitive = 0, cmd_to_sw = 0;
  logic [2:0]    cmd_dest_slot = 0;
  logic          res_valid = 0;
  logic [2:0]    res_slot = 0;
  logic [KW-1:0] res_key = '0;
  logic          res_secure = 0;
  logic [1:0]    res_priv = 0;
  logic          done, err, err_sticky, res_err, use_valid, use_to_sw;
  logic [2:0]    err_code, use_dest_slot;
  logic [KW-1:0] use_key;

  always #5 clk = ~clk;

  slot_keystore u0 (.*);

  int checks = 0, errors = 0;

  // bench model
  logic [KW-1:0] mkey [NS];
  logic [1:0]    mpriv [NS];
  logic          mval [NS], msec [NS], mlock [NS];
  logic [1:0]    mcur;
  logic          msticky;
  logic [2:0]    mcode;

  function automatic logic [KW-1:0] rkey();
    logic [KW-1:0] k;
    for (int i = 0; i < KW/32; i++) k[i*32 +: 32] = $urandom;
    return k;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin
      mkey[i] = '0; mpriv[i] = 0; mval[i] = 0; msec[i] = 0; mlock[i] = 0;
    end
    mcur = 0; msticky = 0; mcode = 0;
  endtask

  // drive current inputs for one cycle, predict, compare on next falling edge
  task automatic cycle();
    logic e_done, e_err, e_uv, e_rerr, e_sw, cbad;
    logic [KW-1:0] e_key;
    logic [2:0] e_dest, ccode, rcode;
    string tag;
    e_done = 0; e_err = 0; e_uv = 0; e_rerr = 0; e_key = '0; e_dest = 0; e_sw = 0;
    cbad = 0; ccode = 0; rcode = 0; tag = "R10";
    if (cmd_valid) begin
      case (cmd_op)
        2'd0, 2'd1: begin
          tag = (cmd_op == 0) ? "R2" : "R8";
          if (mlock[cmd_slot]) begin cbad = 1; ccode = 2; tag = "R7"; end
        end
        2'd2: tag = "R9";
        default: begin
          tag = "R3";
          if (!mval[cmd_slot])                  begin cbad = 1; ccode = 3; tag = "R5"; end
          else if (mpriv[cmd_slot] < mcur)      begin cbad = 1; ccode = 1; tag = "R4"; end
          else if (msec[cmd_slot] && cmd_sensitive && cmd_to_sw)
                                                begin cbad = 1; ccode = 4; tag = "R6"; end
        end
      endcase
      e_done = !cbad; e_err = cbad;
      if (!cbad && cmd_op == 3) begin
        e_uv = 1; e_key = mkey[cmd_slot]; e_dest = cmd_dest_slot; e_sw = cmd_to_sw;
      end
    end
    if (res_valid) begin
      if (cmd_valid && cmd_op <= 1 && cmd_slot == res_slot) begin e_rerr = 1; rcode = 5; end
      else if (mlock[res_slot]) begin e_rerr = 1; rcode = 2; end
      if (!cmd_valid) tag = "R12";
    end
    if (cbad) mcode = ccode; else if (e_rerr) mcode = rcode;
    if (cbad || e_rerr) msticky = 1;
    // state updates
    if (cmd_valid && !cbad) begin
      if (cmd_op == 0) begin
        mkey[cmd_slot] = cmd_key; mpriv[cmd_slot] = cmd_priv; mval[cmd_slot] = 1;
        msec[cmd_slot] = cmd_secure; mlock[cmd_slot] = cmd_lock;
      end else if (cmd_op == 1) begin
        mkey[cmd_slot] = '0; mpriv[cmd_slot] = 0; mval[cmd_slot] = 0; msec[cmd_slot] = 0;
      end else if (cmd_op == 2) mcur = cmd_priv;
    end
    if (res_valid && !e_rerr) begin
      mkey[res_slot] = res_key; mpriv[res_slot] = res_priv; mval[res_slot] = 1;
      msec[res_slot] = res_secure; mlock[res_slot] = 0;
    end
    @(negedge clk);
    checks++;
    if (done !== e_done || err !== e_err || err_code !== mcode || err_sticky !== msticky ||
        res_err !== e_rerr || use_valid !== e_uv || use_key !== e_key ||
        use_dest_slot !== e_dest || use_to_sw !== e_sw) begin
      errors++;
      $display("FAIL %s: act done=%b err=%b code=%0d sticky=%b rerr=%b uv=%b dest=%0d sw=%b key=%h | exp done=%b err=%b code=%0d sticky=%b rerr=%b uv=%b dest=%0d sw=%b key=%h",
        tag, done, err, err_code, err_sticky, res_err, use_valid, use_dest_slot, use_to_sw, use_key,
        e_done, e_err, mcode, msticky, e_rerr, e_uv, e_dest, e_sw, e_key);
    end
    cmd_valid = 0; res_valid = 0;
  endtask

  task automatic t_load(input int s, input logic [KW-1:0] k, input int p, input bit sec, input bit lk);
    cmd_valid = 1; cmd_op = 0; cmd_slot = 3'(s); cmd_key = k; cmd_priv = 2'(p);
    cmd_secure = sec; cmd_lock = lk; cycle();
  endtask
  task automatic t_inval(input int s);
    cmd_valid = 1; cmd_op = 1; cmd_slot = 3'(s); cycle();
  endtask
  task automatic t_priv(input int p);
    cmd_valid = 1; cmd_op = 2; cmd_priv = 2'(p); cycle();
  endtask
  task automatic t_use(input int s, input bit sens, input bit sw, input int d);
    cmd_valid = 1; cmd_op = 3; cmd_slot = 3'(s); cmd_sensitive = sens;
    cmd_to_sw = sw; cmd_dest_slot = 3'(d); cycle();
  endtask
  task automatic set_res(input int s, input logic [KW-1:0] k, input int p, input bit sec);
    res_valid = 1; res_slot = 3'(s); res_key = k; res_priv = 2'(p); res_secure = sec;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cmd_valid = 0; res_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; model_reset();
    repeat (3) @(negedge clk);
    checks++;   // R1: quiet outputs after reset
    if (done || err || err_code != 0 || err_sticky || res_err || use_valid || use_key != '0) begin
      errors++;
      $display("FAIL R1: act done=%b err=%b code=%0d sticky=%b uv=%b | exp all zero",
               done, err, err_code, err_sticky, use_valid);
    end
  endtask

  logic [KW-1:0] k0, k3;
  bit finished = 0;

  initial begin
    #(1_500_000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    model_reset();
    do_reset();
    // R1 / R5: every slot invalid after reset
    for (int i = 0; i < NS; i++) t_use(i, 0, 1, 0);
    // R2 / R3 / R1: priv 0 slot usable only if current priv is 0
    k0 = rkey(); t_load(0, k0, 0, 0, 0); t_use(0, 0, 1, 2);
    // R9 / R4 / R3 boundary equal privilege
    t_priv(2); t_use(0, 0, 1, 0);
    t_load(1, rkey(), 2, 0, 0); t_use(1, 1, 1, 0);
    // R6 secure routing
    t_load(2, rkey(), 3, 1, 0);
    t_use(2, 1, 1, 0); t_use(2, 1, 0, 5); t_use(2, 0, 1, 0);
    // R7 lock
    k3 = rkey(); t_load(3, k3, 3, 0, 1);
    t_load(3, rkey(), 3, 0, 0); t_inval(3); t_use(3, 0, 1, 0);
    // R8 invalidate
    t_inval(1); t_use(1, 0, 1, 0);
    // R12 result sink: plain write, locked target, clash
    set_res(4, rkey(), 3, 1); cycle();
    t_use(4, 1, 0, 6);
    set_res(3, rkey(), 3, 0); cycle();
    set_res(5, rkey(), 3, 0); t_load(5, rkey(), 3, 0, 0);
    // R11: command error wins over sink error
    set_res(3, rkey(), 1, 0); t_use(7, 0, 0, 0);
    t_use(5, 0, 1, 0);
    // R10 idle
    cycle(); cycle();
    // R1: reset clears locks and privilege
    do_reset();
    t_use(3, 0, 1, 0);
    t_load(3, rkey(), 0, 0, 0); t_use(3, 0, 1, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0)
        set_res($urandom_range(0, 7), rkey(), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
      if (op <= 2)      t_load($urandom_range(0, 7), rkey(), $urandom_range(0, 3),
                               1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0));
      else if (op == 3) t_inval($urandom_range(0, 7));
      else if (op == 4) t_priv($urandom_range(0, 3));
      else if (op == 5) cycle();
      else              t_use($urandom_range(0, 7), 1'($urandom_range(0, 1)),
                              1'($urandom_range(0, 1)), $urandom_range(0, 7));
      if (n == 300) do_reset();
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule